// File: doc/BRIEF.md
# TMDS Character Decoder and Control Demapper

This block takes three 10-bit TMDS characters per pixel clock, one per channel, which are already aligned. It works out the display-enable state from the kind of character received: pixel data or control code. Each data character becomes an 8-bit colour component. Each control code becomes two control bits, and these are routed to HSYNC, VSYNC and two user control outputs. No separate enable signal is sent on the link. The decoder must infer it.

Each input word qualifies with a valid strobe. Every output is registered, and a result appears exactly two clock cycles after the character that produced it. A small state machine tracks the link. It has four states:

- `ST_IDLE`: the state after reset.
- `ST_LEAD`: the first blanking run after reset. Its start was not observed, so its length is not judged.
- `ST_BLANK`: a blanking run that followed active video.
- `ST_ACTIVE`: active video.

It has these transitions:

- `ST_IDLE`→`ST_ACTIVE` on an all-data cycle.
- `ST_IDLE`→`ST_LEAD` on an all-control cycle.
- `ST_LEAD`→`ST_ACTIVE` on an all-data cycle.
- `ST_BLANK`→`ST_ACTIVE` on an all-data cycle. This transition is where the run length is checked.
- `ST_ACTIVE`→`ST_BLANK` on an all-control cycle.

A cycle in which the three channels disagree never changes the state.

Top module: `tmds_char_demap`

## Requirements
- R1: A data character decodes in two steps. First, bits 7:0 are inverted when bit 9 is 1. Then output bit 0 equals that intermediate bit 0, and each output bit i (i from 1 to 7) is the XOR of intermediate bits i and i-1 when bit 8 is 1, or their XNOR when bit 8 is 0. The result is exactly the byte the transmitter encoded.
- R2: The decoded component from channel 2 drives `red`, from channel 1 drives `green`, and from channel 0 drives `blue`.
- R3: The control codes 10'b1101010100, 10'b0010101011, 10'b0101010100 and 10'b1010101011 decode to the 2-bit values 0, 1, 2 and 3. On channel 0, bit 0 of the value drives `hsync` and bit 1 drives `vsync`.
- R4: On channel 1, bit 1 of the value drives `ctl1` and bit 0 has no effect on any output. On channel 2, bit 0 drives `ctl2` and bit 1 reaches no output.
- R5: `de` goes to 1 when all three channels carry data characters, and to 0 when all three carry control codes. Any 10-bit word that is not one of the four control codes counts as data.
- R6: When the channels disagree on the character kind, `mix_err` pulses for that result. In the same result, `de`, the colour outputs and the control outputs keep their previous values.
- R7: `hsync`, `vsync`, `ctl1` and `ctl2` hold their last decoded values while `de` is 1.
- R8: While `de` is 0, `red`, `green` and `blue` are 0.
- R9: A blanking run counts only the cycles in which all three channels carry control codes. If such a run follows active video and has fewer than MIN_BLANK (default 128) control cycles, `short_blank_err` pulses with the first data result after it. A run of exactly MIN_BLANK cycles does not set the flag, and neither does the first run after reset.
- R10: `out_valid` equals `in_valid` delayed by two cycles. In cycles without valid input, all outputs hold and both error flags stay 0.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The three characters are valid this cycle |
| ch0_char | input | 10 | Channel 0 character (blue / sync) |
| ch1_char | input | 10 | Channel 1 character (green / ctl1) |
| ch2_char | input | 10 | Channel 2 character (red / ctl2) |
| out_valid | output | 1 | Result of a valid input character set |
| de | output | 1 | Derived display enable |
| red | output | 8 | Red component |
| green | output | 8 | Green component |
| blue | output | 8 | Blue component |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| ctl1 | output | 1 | User control bit 1 |
| ctl2 | output | 1 | User control bit 2 |
| mix_err | output | 1 | Channels disagreed on character kind |
| short_blank_err | output | 1 | Blanking run shorter than MIN_BLANK |

## Verification
Every result, including both error pulses, is due two clock edges after the character set that caused it. One register sits in each channel decoder and one in the output stage. The bench drives inputs on the falling edge. It pushes the expected result for each drive into a two-deep queue and compares the oldest entry at the falling edge two drives later. Expected values come from the bytes and control values the bench encoded itself, so both the hold behaviour and the one-cycle error pulses are checked at exactly that point.

// File: rtl/tmds_demap_pkg.sv
package tmds_demap_pkg;

    localparam int CHAR_W = 10;
    localparam int BYTE_W = 8;
    localparam int NUM_CH = 3;

    localparam logic [CHAR_W-1:0] CODE_V0 = 10'b1101010100;
    localparam logic [CHAR_W-1:0] CODE_V1 = 10'b0010101011;
    localparam logic [CHAR_W-1:0] CODE_V2 = 10'b0101010100;
    localparam logic [CHAR_W-1:0] CODE_V3 = 10'b1010101011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BLANK,
        ST_ACTIVE
    } link_state_e;

    typedef struct packed {
        logic              is_ctl;
        logic [1:0]        ctl;
        logic [BYTE_W-1:0] pix;
    } chan_word_t;

    function automatic chan_word_t classify(input logic [CHAR_W-1:0] c);
        chan_word_t        w;
        logic [BYTE_W-1:0] m;
        w.is_ctl = 1'b1;
        w.ctl    = 2'd0;
        case (c)
            CODE_V0: w.ctl = 2'd0;
            CODE_V1: w.ctl = 2'd1;
            CODE_V2: w.ctl = 2'd2;
            CODE_V3: w.ctl = 2'd3;
            default: w.is_ctl = 1'b0;
        endcase
        m = c[9] ? ~c[BYTE_W-1:0] : c[BYTE_W-1:0];
        w.pix[0] = m[0];
        for (int i = 1; i < BYTE_W; i++) begin
            w.pix[i] = c[8] ? (m[i] ^ m[i-1]) : ~(m[i] ^ m[i-1]);
        end
        return w;
    endfunction

endpackage

// File: rtl/tmds_chan_dec.sv
module tmds_chan_dec
    import tmds_demap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [CHAR_W-1:0] char_i,
    output chan_word_t        word_o
);

    chan_word_t word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (valid_i) begin
            word_q <= classify(char_i);
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/tmds_link_fsm.sv
module tmds_link_fsm
    import tmds_demap_pkg::*;
#(
    parameter int MIN_BLANK = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic v_i,
    input  logic all_data_i,
    input  logic all_ctl_i,
    output logic mix_o,
    output logic short_o
);

    localparam int CW = $clog2(MIN_BLANK + 1);

    link_state_e state_q, state_d;
    logic [CW-1:0] run_q;

    always_comb begin
        state_d = state_q;
        if (v_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (all_data_i)     state_d = ST_ACTIVE;
                    else if (all_ctl_i) state_d = ST_LEAD;
                end
                ST_LEAD:   if (all_data_i) state_d = ST_ACTIVE;
                ST_BLANK:  if (all_data_i) state_d = ST_ACTIVE;
                ST_ACTIVE: if (all_ctl_i)  state_d = ST_BLANK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            if (v_i && all_ctl_i) begin
                if (state_q == ST_ACTIVE) begin
                    run_q <= CW'(1);
                end else if (state_q == ST_BLANK && run_q < CW'(MIN_BLANK)) begin
                    run_q <= run_q + CW'(1);
                end
            end
        end
    end

    always_comb begin
        mix_o   = v_i && !all_data_i && !all_ctl_i;
        short_o = v_i && all_data_i && (state_q == ST_BLANK) && (run_q < CW'(MIN_BLANK));
    end

    p_run_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(MIN_BLANK));

    p_lead_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/tmds_char_demap.sv
module tmds_char_demap
    import tmds_demap_pkg::*;
#(
    parameter int MIN_BLANK = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] ch0_char,
    input  logic [CHAR_W-1:0] ch1_char,
    input  logic [CHAR_W-1:0] ch2_char,
    output logic              out_valid,
    output logic              de,
    output logic [BYTE_W-1:0] red,
    output logic [BYTE_W-1:0] green,
    output logic [BYTE_W-1:0] blue,
    output logic              hsync,
    output logic              vsync,
    output logic              ctl1,
    output logic              ctl2,
    output logic              mix_err,
    output logic              short_blank_err
);

    logic [CHAR_W-1:0] chars [NUM_CH];
    chan_word_t        words [NUM_CH];
    logic              s1_v;
    logic              all_ctl, all_data;
    logic              mix_c, short_c;
    logic              hidden_ctl_q;
    logic              unused_sink;

    assign chars[0] = ch0_char;
    assign chars[1] = ch1_char;
    assign chars[2] = ch2_char;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmds_chan_dec u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (in_valid),
            .char_i  (chars[g]),
            .word_o  (words[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_v <= 1'b0;
        else        s1_v <= in_valid;
    end

    always_comb begin
        all_ctl  = 1'b1;
        all_data = 1'b1;
        for (int k = 0; k < NUM_CH; k++) begin
            all_ctl  = all_ctl  & words[k].is_ctl;
            all_data = all_data & !words[k].is_ctl;
        end
    end

    tmds_link_fsm #(.MIN_BLANK(MIN_BLANK)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .v_i        (s1_v),
        .all_data_i (all_data),
        .all_ctl_i  (all_ctl),
        .mix_o      (mix_c),
        .short_o    (short_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            de              <= 1'b0;
            red             <= '0;
            green           <= '0;
            blue            <= '0;
            hsync           <= 1'b0;
            vsync           <= 1'b0;
            ctl1            <= 1'b0;
            ctl2            <= 1'b0;
            hidden_ctl_q    <= 1'b0;
            mix_err         <= 1'b0;
            short_blank_err <= 1'b0;
        end else begin
            out_valid       <= s1_v;
            mix_err         <= mix_c;
            short_blank_err <= short_c;
            if (s1_v && all_data) begin
                de    <= 1'b1;
                red   <= words[2].pix;
                green <= words[1].pix;
                blue  <= words[0].pix;
            end else if (s1_v && all_ctl) begin
                de           <= 1'b0;
                red          <= '0;
                green        <= '0;
                blue         <= '0;
                hsync        <= words[0].ctl[0];
                vsync        <= words[0].ctl[1];
                ctl1         <= words[1].ctl[1];
                ctl2         <= words[2].ctl[0];
                hidden_ctl_q <= words[2].ctl[1];
            end
        end
    end

    assign unused_sink = ^{words[1].ctl[0], hidden_ctl_q};

    p_mix_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mix_err |-> (de == $past(de)) && $stable({red, green, blue}));

    p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> $stable({hsync, vsync, ctl1, ctl2}));

    p_blank_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> ({red, green, blue} == '0));

    p_short_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        short_blank_err |-> de && !$past(de));

    p_err_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mix_err || short_blank_err) |-> out_valid);

endmodule

// File: tb/tmds_char_demap_tb.sv
module tmds_char_demap_tb_top;

    localparam int MINB = 128;

    typedef struct packed {
        logic        v;
        logic        de;
        logic [23:0] rgb;
        logic [3:0]  syn;
        logic        mix;
        logic        shrt;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] ch0 = '0, ch1 = '0, ch2 = '0;
    logic       out_valid, de, hsync, vsync, ctl1, ctl2, mix_err, short_blank_err;
    logic [7:0] red, green, blue;

    int   nchk = 0, nerr = 0;
    int   disp [3];
    exp_t e1, e2;
    int   m_mode = 0, m_cnt = 0;
    logic m_de = 1'b0;
    logic [23:0] m_rgb = '0;
    logic [3:0]  m_syn = '0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    tmds_char_demap #(.MIN_BLANK(MINB)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ch0_char(ch0), .ch1_char(ch1), .ch2_char(ch2),
        .out_valid(out_valid), .de(de), .red(red), .green(green), .blue(blue),
        .hsync(hsync), .vsync(vsync), .ctl1(ctl1), .ctl2(ctl2),
        .mix_err(mix_err), .short_blank_err(short_blank_err)
    );

    function automatic logic [9:0] code_of(input logic [1:0] v);
        case (v)
            2'd0: return 10'b1101010100;
            2'd1: return 10'b0010101011;
            2'd2: return 10'b0101010100;
            default: return 10'b1010101011;
        endcase
    endfunction

    function automatic int ones8(input logic [7:0] x);
        int n = 0;
        for (int i = 0; i < 8; i++) n += x[i];
        return n;
    endfunction

    task automatic enc(input logic [7:0] d, input int ch, output logic [9:0] q);
        logic [8:0] m;
        int n1, n0;
        if (ones8(d) > 4 || (ones8(d) == 4 && d[0] == 1'b0)) begin
            m[0] = d[0];
            for (int i = 1; i < 8; i++) m[i] = ~(m[i-1] ^ d[i]);
            m[8] = 1'b0;
        end else begin
            m[0] = d[0];
            for (int i = 1; i < 8; i++) m[i] = m[i-1] ^ d[i];
            m[8] = 1'b1;
        end
        n1 = ones8(m[7:0]);
        n0 = 8 - n1;
        if (disp[ch] == 0 || n1 == n0) begin
            q = {~m[8], m[8], m[8] ? m[7:0] : ~m[7:0]};
            disp[ch] += m[8] ? (n1 - n0) : (n0 - n1);
        end else if ((disp[ch] > 0 && n1 > n0) || (disp[ch] < 0 && n0 > n1)) begin
            q = {1'b1, m[8], ~m[7:0]};
            disp[ch] += (m[8] ? 2 : 0) + n0 - n1;
        end else begin
            q = {1'b0, m[8], m[7:0]};
            disp[ch] += -(m[8] ? 0 : 2) + n1 - n0;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        chk("R10 out_valid", 32'(out_valid), 32'(e.v));
        chk("R5 de", 32'(de), 32'(e.de));
        chk("R1 R2 R8 pixel", 32'({red, green, blue}), 32'(e.rgb));
        chk("R3 R4 R7 sync", 32'({hsync, vsync, ctl1, ctl2}), 32'(e.syn));
        chk("R6 mix_err", 32'(mix_err), 32'(e.mix));
        chk("R9 short_blank_err", 32'(short_blank_err), 32'(e.shrt));
    endtask

    task automatic apply(input logic v, input logic [9:0] k0, k1, k2, input exp_t e);
        @(negedge clk);
        compare(e2);
        e2 = e1;
        in_valid = v;
        ch0 = k0; ch1 = k1; ch2 = k2;
        e1 = e;
    endtask

    function automatic exp_t snap(input logic v, input logic mix, input logic shrt);
        exp_t e;
        e.v = v; e.de = m_de; e.rgb = m_rgb; e.syn = m_syn; e.mix = mix; e.shrt = shrt;
        return e;
    endfunction

    task automatic send_pix(input logic [7:0] r, g, b);
        logic [9:0] k0, k1, k2;
        logic sh;
        enc(b, 0, k0); enc(g, 1, k1); enc(r, 2, k2);
        sh = (m_mode == 2 && m_cnt < MINB);
        m_mode = 3; m_de = 1'b1; m_rgb = {r, g, b};
        apply(1'b1, k0, k1, k2, snap(1'b1, 1'b0, sh));
    endtask

    task automatic send_ctl(input logic [1:0] c0, c1, c2);
        if (m_mode == 3) begin m_mode = 2; m_cnt = 1; end
        else if (m_mode == 2) m_cnt++;
        else if (m_mode == 0) m_mode = 1;
        m_de = 1'b0; m_rgb = '0;
        m_syn = {c0[0], c0[1], c1[1], c2[0]};
        apply(1'b1, code_of(c0), code_of(c1), code_of(c2), snap(1'b1, 1'b0, 1'b0));
    endtask

    task automatic send_mix();
        logic [9:0] k1, k2;
        enc(8'($urandom), 1, k1); enc(8'($urandom), 2, k2);
        apply(1'b1, code_of(2'($urandom)), k1, k2, snap(1'b1, 1'b1, 1'b0));
    endtask

    task automatic send_idle();
        apply(1'b0, 10'($urandom), 10'($urandom), 10'($urandom), snap(1'b0, 1'b0, 1'b0));
    endtask

    task automatic blank_run(input int n);
        for (int i = 0; i < n; i++) send_ctl(2'($urandom), 2'($urandom), 2'($urandom));
    endtask

    task automatic active_run(input int n);
        for (int i = 0; i < n; i++) send_pix(8'($urandom), 8'($urandom), 8'($urandom));
    endtask

    initial begin
        void'($urandom(32'd1357));
        for (int c = 0; c < 3; c++) disp[c] = 0;
        e1 = '0; e2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset values at the ports
        chk("R11 reset outputs", 32'({out_valid, de, red, green, blue, hsync, vsync, ctl1, ctl2,
            mix_err, short_blank_err}), 32'd0);
        // R3 R4: every code value on every channel in the leading (unjudged) run
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) send_ctl(2'(a), 2'(b), 2'(3 - a));
        // R1 R2: directed corner bytes
        send_pix(8'h00, 8'hFF, 8'h55);
        send_pix(8'hAA, 8'h01, 8'h80);
        send_pix(8'hFF, 8'h00, 8'h0F);
        active_run(40);
        send_idle(); send_idle(); send_idle();   // R10 gap mid-line
        active_run(5);
        send_mix();                              // R6 in active
        active_run(5);
        blank_run(MINB);                         // R9 exactly MIN_BLANK: no flag
        active_run(10);
        blank_run(MINB - 1);                     // R9 one short: flag
        active_run(5);
        send_ctl(2'd1, 2'd2, 2'd1); send_mix(); send_ctl(2'd3, 2'd1, 2'd2); // R6 in blank, R9 short
        active_run(3);
        blank_run(60); send_mix(); blank_run(MINB - 60); // mix not counted: MINB ctl cycles total
        active_run(4);
        for (int line = 0; line < 8; line++) begin
            for (int i = 0; i < MINB + int'($urandom % 40); i++) begin
                if ($urandom % 8 == 0) send_idle();
                send_ctl(2'($urandom), 2'($urandom), 2'($urandom));
            end
            for (int i = 0; i < 20 + int'($urandom % 40); i++) begin
                if ($urandom % 8 == 0) send_idle();
                send_pix(8'($urandom), 8'($urandom), 8'($urandom));
            end
        end
        send_idle(); send_idle(); send_idle();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired R10 actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule